// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block computes host-memory descriptor addresses for three circular rings that a storage adapter shares with its driver: a request ring the host fills, a completion ring the adapter fills, and a message ring the adapter fills with event notices. A ring is not contiguous. Each ring owns a small table of page frame numbers, and a slot index is turned into an address by picking the page that holds the slot and adding the slot's byte offset inside that page.

Software first writes page frame numbers through a table port. A setup strobe then latches the page counts, derives each ring's wrap mask and log2 entry count, and zeroes the ring counters and the published indices. The request ring pops only when the host producer index differs from the internal consumed counter. The completion and message rings always hand out the next free slot. Flush strobes publish the counters so that a write-back engine can store them in the shared ring state. Memory traffic and descriptor contents belong to neighbouring logic.

Top module: `pdr_addr_gen`

## Requirements
- R1: On setup, the ring size is page count times entries per page. The reported log2 entry count is the bit position of the highest set bit of (size-1), plus one. The wrap mask has that many low bits set. Examples: 2 pages of 32 give 6, 1 page of 128 gives 7, 3 pages of 32 give 7.
- R2: A request pop hits only when `req_host_prod_i` differs from the consumed counter. A miss responds with hit 0 and address 0 and leaves the counter unchanged.
- R3: A request hit uses slot = counter AND mask. The counter then increments and is never masked, so it runs past the ring size while the slots wrap.
- R4: The page is slot / entries-per-page and the in-page index is slot mod entries-per-page. The address is (page frame << 12) + index * descriptor size. Defaults: request 32 entries of 128 bytes, completion 128 of 32 bytes, message 32 of 128 bytes. A page beyond the table reads as frame 0.
- R5: Completion and message pops never check for overflow. Every pop returns an address and advances the filled counter.
- R6: `msg_room_o` is 1 only when the message ring is configured and (host producer - host consumer) mod 2^32 < mask + 1.
- R7: Message setup takes effect only when the data rings were configured at an earlier edge. Otherwise it is ignored, and log2 and room stay 0.
- R8: Flush publishes a counter. For the request ring it is the consumed counter. For the completion and message rings it is the filled counter. A pop in the same cycle is included. `pub_upd_o` bit 0 (request), bit 1 (completion) or bit 2 (message) pulses for one cycle.
- R9: Setup zeroes the configured ring's counter and published index and pulses its `pub_upd_o` bit. The next pop uses slot 0.
- R10: Reset and `clear_i` zero all masks, log2 counts, counters, published indices, page tables and configured flags. Clear overrides setup and pop in the same cycle.
- R11: A pop is answered by a one-cycle `*_rsp_vld_o` pulse on the next clock edge.
- R12: A page table write selects its ring with `pt_ring_i`: 0 request, 1 completion, 2 message. Code 3 writes nothing. A slot beyond a ring's table depth is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Zeroes all ring state |
| setup_data_i | input | 1 | Configure request and completion rings |
| setup_msg_i | input | 1 | Configure message ring |
| req_npages_i | input | 6 | Request ring page count |
| cmp_npages_i | input | 6 | Completion ring page count |
| msg_npages_i | input | 5 | Message ring page count |
| pt_we_i | input | 1 | Page table write strobe |
| pt_ring_i | input | 2 | Page table ring select |
| pt_slot_i | input | 5 | Page table entry select |
| pt_ppn_i | input | 36 | Page frame number written |
| req_pop_i | input | 1 | Request pop |
| req_host_prod_i | input | 32 | Host request producer index |
| cmp_pop_i | input | 1 | Completion pop |
| msg_pop_i | input | 1 | Message pop |
| msg_host_prod_i | input | 32 | Host message producer index |
| msg_host_cons_i | input | 32 | Host message consumer index |
| req_flush_i | input | 1 | Publish request consumer index |
| cmp_flush_i | input | 1 | Publish completion producer index |
| msg_flush_i | input | 1 | Publish message producer index |
| req_rsp_vld_o | output | 1 | Request pop answered |
| req_rsp_hit_o | output | 1 | Request pop found a descriptor |
| req_rsp_addr_o | output | 48 | Request descriptor address, 0 on miss |
| cmp_rsp_vld_o | output | 1 | Completion pop answered |
| cmp_rsp_addr_o | output | 48 | Completion slot address |
| msg_rsp_vld_o | output | 1 | Message pop answered |
| msg_rsp_addr_o | output | 48 | Message slot address |
| req_log2_o | output | 6 | Request ring log2 entry count |
| cmp_log2_o | output | 6 | Completion ring log2 entry count |
| msg_log2_o | output | 6 | Message ring log2 entry count |
| req_cons_pub_o | output | 32 | Published request consumer index |
| cmp_prod_pub_o | output | 32 | Published completion producer index |
| msg_prod_pub_o | output | 32 | Published message producer index |
| pub_upd_o | output | 3 | Published index update pulses |
| msg_room_o | output | 1 | Message ring has room |

## Verification
The bench drives the request counter past the ring size so that slot 64 must fold back to page 0. A design that masked the counter itself would publish 6 instead of 70 on flush. A design that skipped the mask would read a page past the table. Message room is probed at the exact full boundary and across 32-bit index wraparound; a non-modular or off-by-one compare reports room on a full ring. It also checks that a message setup before the data rings is ignored, that a page write with ring code 3 does not corrupt the request table, and that clear empties the page tables. A leftover frame would then show up in the address of slot 0.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  parameter int unsigned PDR_IDX_W    = 32;
  parameter int unsigned PDR_PA_W     = 48;
  parameter int unsigned PDR_PG_SHIFT = 12;
  parameter int unsigned PDR_PPN_W    = PDR_PA_W - PDR_PG_SHIFT;
  parameter int unsigned PDR_LG_W     = 6;

  // Width of (size-1): highest set bit position plus one.
  function automatic logic [PDR_LG_W-1:0] f_len_log2(input logic [PDR_IDX_W-1:0] size);
    logic [PDR_IDX_W-1:0] v;
    logic [PDR_LG_W-1:0]  lg;
    v  = size - 1'b1;
    lg = '0;
    for (int i = 0; i < int'(PDR_IDX_W); i++) begin
      if (v[i]) lg = PDR_LG_W'(i + 1);
    end
    return lg;
  endfunction

  function automatic logic [PDR_IDX_W-1:0] f_mask(input logic [PDR_LG_W-1:0] lg);
    logic [PDR_IDX_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(PDR_IDX_W); i++) begin
      m[i] = (i < int'(lg));
    end
    return m;
  endfunction

  function automatic logic [PDR_PA_W-1:0] f_slot_addr(input logic [PDR_PPN_W-1:0] ppn,
                                                       input logic [PDR_IDX_W-1:0] inpg,
                                                       input int unsigned dsz);
    return {ppn, {PDR_PG_SHIFT{1'b0}}} + (PDR_PA_W'(inpg) * PDR_PA_W'(dsz));
  endfunction
endpackage

// File: rtl/pdr_page_table.sv
module pdr_page_table import pdr_pkg::*; #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned SLOT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [SLOT_W-1:0]    wslot_i,
  input  logic [PDR_PPN_W-1:0] wppn_i,
  input  logic [PDR_IDX_W-1:0] rpage_i,
  output logic [PDR_PPN_W-1:0] rppn_o
);
  localparam int unsigned PG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][PDR_PPN_W-1:0] tbl_q;
  logic                            w_in_range;
  logic                            r_in_range;

  assign w_in_range = ({1'b0, wslot_i} < (SLOT_W+1)'(DEPTH));
  assign r_in_range = (rpage_i < PDR_IDX_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (clr_i) begin
      tbl_q <= '0;
    end else if (we_i && w_in_range) begin
      tbl_q[wslot_i[PG_W-1:0]] <= wppn_i;
    end
  end

  assign rppn_o = r_in_range ? tbl_q[rpage_i[PG_W-1:0]] : '0;
endmodule

// File: rtl/pdr_lane.sv
module pdr_lane import pdr_pkg::*; #(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned EPP        = 32,
  parameter int unsigned DSZ        = 128,
  parameter bit          CHECK_PROD = 1'b0,
  parameter int unsigned SLOT_W     = 5,
  localparam int unsigned NPG_W     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 setup_i,
  input  logic [NPG_W-1:0]     npages_i,
  input  logic                 pt_we_i,
  input  logic [SLOT_W-1:0]    pt_slot_i,
  input  logic [PDR_PPN_W-1:0] pt_ppn_i,
  input  logic                 pop_i,
  input  logic [PDR_IDX_W-1:0] host_prod_i,
  input  logic                 flush_i,
  output logic                 rsp_vld_o,
  output logic                 rsp_hit_o,
  output logic [PDR_PA_W-1:0]  rsp_addr_o,
  output logic [PDR_LG_W-1:0]  log2_o,
  output logic [PDR_IDX_W-1:0] ctr_o,
  output logic [PDR_IDX_W-1:0] pub_o,
  output logic                 pub_upd_o,
  output logic                 take_o
);
  localparam int unsigned EPP_LG = $clog2(EPP);

  logic [PDR_IDX_W-1:0] ctr_q, mask_q, pub_q, ctr_nxt;
  logic [PDR_LG_W-1:0]  lg_q, lg_new;
  logic [PDR_IDX_W-1:0] size_w, slot_w, page_w, inpg_w;
  logic [PDR_PPN_W-1:0] ppn_w;
  logic [PDR_PA_W-1:0]  addr_w;
  logic                 hit_w, busy_w, take_w;

  assign size_w = PDR_IDX_W'(npages_i) * PDR_IDX_W'(EPP);
  assign lg_new = f_len_log2(size_w);
  assign slot_w = ctr_q & mask_q;
  assign page_w = slot_w >> EPP_LG;
  assign inpg_w = slot_w & PDR_IDX_W'(EPP - 1);

  pdr_page_table #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) pt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .we_i    (pt_we_i),
    .wslot_i (pt_slot_i),
    .wppn_i  (pt_ppn_i),
    .rpage_i (page_w),
    .rppn_o  (ppn_w)
  );

  assign addr_w = f_slot_addr(ppn_w, inpg_w, DSZ);

  generate
    if (CHECK_PROD) begin : g_gated
      assign hit_w = (host_prod_i != ctr_q);
    end else begin : g_free
      assign hit_w = 1'b1 | (|host_prod_i);
    end
  endgenerate

  assign busy_w  = clr_i | setup_i;
  assign take_w  = pop_i & hit_w & ~busy_w;
  assign ctr_nxt = take_w ? ctr_q + 1'b1 : ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q      <= '0;
      mask_q     <= '0;
      lg_q       <= '0;
      pub_q      <= '0;
      pub_upd_o  <= 1'b0;
      rsp_vld_o  <= 1'b0;
      rsp_hit_o  <= 1'b0;
      rsp_addr_o <= '0;
    end else begin
      rsp_vld_o <= 1'b0;
      pub_upd_o <= 1'b0;
      if (clr_i) begin
        ctr_q  <= '0;
        mask_q <= '0;
        lg_q   <= '0;
        pub_q  <= '0;
      end else if (setup_i) begin
        ctr_q     <= '0;
        mask_q    <= f_mask(lg_new);
        lg_q      <= lg_new;
        pub_q     <= '0;
        pub_upd_o <= 1'b1;
      end else begin
        ctr_q <= ctr_nxt;
        if (pop_i) begin
          rsp_vld_o  <= 1'b1;
          rsp_hit_o  <= hit_w;
          rsp_addr_o <= hit_w ? addr_w : '0;
        end
        if (flush_i) begin
          pub_q     <= ctr_nxt;
          pub_upd_o <= 1'b1;
        end
      end
    end
  end

  assign log2_o = lg_q;
  assign ctr_o  = ctr_q;
  assign pub_o  = pub_q;
  assign take_o = take_w;
endmodule

// File: rtl/pdr_addr_gen.sv
module pdr_addr_gen import pdr_pkg::*; #(
  parameter int unsigned REQ_PAGES = 32,
  parameter int unsigned CMP_PAGES = 32,
  parameter int unsigned MSG_PAGES = 16,
  parameter int unsigned REQ_EPP   = 32,
  parameter int unsigned REQ_DSZ   = 128,
  parameter int unsigned CMP_EPP   = 128,
  parameter int unsigned CMP_DSZ   = 32,
  parameter int unsigned MSG_EPP   = 32,
  parameter int unsigned MSG_DSZ   = 128,
  localparam int unsigned MAX_AB   = (REQ_PAGES > CMP_PAGES) ? REQ_PAGES : CMP_PAGES,
  localparam int unsigned MAX_PG   = (MAX_AB > MSG_PAGES) ? MAX_AB : MSG_PAGES,
  localparam int unsigned SLOT_W   = $clog2(MAX_PG),
  localparam int unsigned RNPG_W   = $clog2(REQ_PAGES + 1),
  localparam int unsigned CNPG_W   = $clog2(CMP_PAGES + 1),
  localparam int unsigned MNPG_W   = $clog2(MSG_PAGES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 setup_data_i,
  input  logic                 setup_msg_i,
  input  logic [RNPG_W-1:0]    req_npages_i,
  input  logic [CNPG_W-1:0]    cmp_npages_i,
  input  logic [MNPG_W-1:0]    msg_npages_i,
  input  logic                 pt_we_i,
  input  logic [1:0]           pt_ring_i,
  input  logic [SLOT_W-1:0]    pt_slot_i,
  input  logic [PDR_PPN_W-1:0] pt_ppn_i,
  input  logic                 req_pop_i,
  input  logic [PDR_IDX_W-1:0] req_host_prod_i,
  input  logic                 cmp_pop_i,
  input  logic                 msg_pop_i,
  input  logic [PDR_IDX_W-1:0] msg_host_prod_i,
  input  logic [PDR_IDX_W-1:0] msg_host_cons_i,
  input  logic                 req_flush_i,
  input  logic                 cmp_flush_i,
  input  logic                 msg_flush_i,
  output logic                 req_rsp_vld_o,
  output logic                 req_rsp_hit_o,
  output logic [PDR_PA_W-1:0]  req_rsp_addr_o,
  output logic                 cmp_rsp_vld_o,
  output logic [PDR_PA_W-1:0]  cmp_rsp_addr_o,
  output logic                 msg_rsp_vld_o,
  output logic [PDR_PA_W-1:0]  msg_rsp_addr_o,
  output logic [PDR_LG_W-1:0]  req_log2_o,
  output logic [PDR_LG_W-1:0]  cmp_log2_o,
  output logic [PDR_LG_W-1:0]  msg_log2_o,
  output logic [PDR_IDX_W-1:0] req_cons_pub_o,
  output logic [PDR_IDX_W-1:0] cmp_prod_pub_o,
  output logic [PDR_IDX_W-1:0] msg_prod_pub_o,
  output logic [2:0]           pub_upd_o,
  output logic                 msg_room_o
);
  // Named internal events, observed by the bound checker.
  logic                 data_rdy_q, msg_rdy_q;
  logic                 msg_setup_eff;
  logic                 req_take, cmp_take, msg_take;
  logic                 cmp_hit, msg_hit;
  logic [PDR_IDX_W-1:0] req_ctr, cmp_ctr, msg_ctr;
  logic                 pt_we_req, pt_we_cmp, pt_we_msg;
  logic [PDR_IDX_W:0]   msg_used, msg_cap;

  assign pt_we_req     = pt_we_i && (pt_ring_i == 2'd0);
  assign pt_we_cmp     = pt_we_i && (pt_ring_i == 2'd1);
  assign pt_we_msg     = pt_we_i && (pt_ring_i == 2'd2);
  assign msg_setup_eff = setup_msg_i & data_rdy_q & ~clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_rdy_q <= 1'b0;
      msg_rdy_q  <= 1'b0;
    end else if (clear_i) begin
      data_rdy_q <= 1'b0;
      msg_rdy_q  <= 1'b0;
    end else begin
      if (setup_data_i)  data_rdy_q <= 1'b1;
      if (msg_setup_eff) msg_rdy_q  <= 1'b1;
    end
  end

  pdr_lane #(.DEPTH(REQ_PAGES), .EPP(REQ_EPP), .DSZ(REQ_DSZ), .CHECK_PROD(1'b1),
             .SLOT_W(SLOT_W)) req_lane_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .setup_i(setup_data_i),
    .npages_i(req_npages_i), .pt_we_i(pt_we_req), .pt_slot_i(pt_slot_i),
    .pt_ppn_i(pt_ppn_i), .pop_i(req_pop_i), .host_prod_i(req_host_prod_i),
    .flush_i(req_flush_i), .rsp_vld_o(req_rsp_vld_o), .rsp_hit_o(req_rsp_hit_o),
    .rsp_addr_o(req_rsp_addr_o), .log2_o(req_log2_o), .ctr_o(req_ctr),
    .pub_o(req_cons_pub_o), .pub_upd_o(pub_upd_o[0]), .take_o(req_take)
  );

  pdr_lane #(.DEPTH(CMP_PAGES), .EPP(CMP_EPP), .DSZ(CMP_DSZ), .CHECK_PROD(1'b0),
             .SLOT_W(SLOT_W)) cmp_lane_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .setup_i(setup_data_i),
    .npages_i(cmp_npages_i), .pt_we_i(pt_we_cmp), .pt_slot_i(pt_slot_i),
    .pt_ppn_i(pt_ppn_i), .pop_i(cmp_pop_i), .host_prod_i('0),
    .flush_i(cmp_flush_i), .rsp_vld_o(cmp_rsp_vld_o), .rsp_hit_o(cmp_hit),
    .rsp_addr_o(cmp_rsp_addr_o), .log2_o(cmp_log2_o), .ctr_o(cmp_ctr),
    .pub_o(cmp_prod_pub_o), .pub_upd_o(pub_upd_o[1]), .take_o(cmp_take)
  );

  pdr_lane #(.DEPTH(MSG_PAGES), .EPP(MSG_EPP), .DSZ(MSG_DSZ), .CHECK_PROD(1'b0),
             .SLOT_W(SLOT_W)) msg_lane_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .setup_i(msg_setup_eff),
    .npages_i(msg_npages_i), .pt_we_i(pt_we_msg), .pt_slot_i(pt_slot_i),
    .pt_ppn_i(pt_ppn_i), .pop_i(msg_pop_i), .host_prod_i('0),
    .flush_i(msg_flush_i), .rsp_vld_o(msg_rsp_vld_o), .rsp_hit_o(msg_hit),
    .rsp_addr_o(msg_rsp_addr_o), .log2_o(msg_log2_o), .ctr_o(msg_ctr),
    .pub_o(msg_prod_pub_o), .pub_upd_o(pub_upd_o[2]), .take_o(msg_take)
  );

  // Modular occupancy against ring capacity, one extra bit so a full-width mask cannot overflow.
  assign msg_used   = {1'b0, msg_host_prod_i - msg_host_cons_i};
  assign msg_cap    = {1'b0, f_mask(msg_log2_o)} + 1'b1;
  assign msg_room_o = msg_rdy_q & (msg_used < msg_cap);
endmodule

// File: rtl/pdr_addr_gen_chk.sv
module pdr_addr_gen_chk import pdr_pkg::*; (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear_i,
  input logic                 setup_data_i,
  input logic                 setup_msg_i,
  input logic                 req_pop_i,
  input logic                 cmp_pop_i,
  input logic                 req_flush_i,
  input logic                 req_rsp_vld_o,
  input logic                 req_rsp_hit_o,
  input logic [PDR_PA_W-1:0]  req_rsp_addr_o,
  input logic                 cmp_rsp_vld_o,
  input logic                 msg_rsp_vld_o,
  input logic                 cmp_hit,
  input logic                 msg_hit,
  input logic                 req_take,
  input logic                 cmp_take,
  input logic                 msg_take,
  input logic [PDR_IDX_W-1:0] req_ctr,
  input logic [PDR_IDX_W-1:0] cmp_ctr,
  input logic [PDR_IDX_W-1:0] msg_ctr,
  input logic                 data_rdy_q,
  input logic                 msg_rdy_q,
  input logic                 msg_room_o,
  input logic [PDR_LG_W-1:0]  req_log2_o,
  input logic [PDR_LG_W-1:0]  cmp_log2_o,
  input logic [PDR_LG_W-1:0]  msg_log2_o,
  input logic [2:0]           pub_upd_o
);
  a_r11_rsp_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
    req_rsp_vld_o |-> $past(req_pop_i));

  a_r2_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rsp_vld_o && !req_rsp_hit_o) |-> (req_rsp_addr_o == '0));

  a_r2_miss_holds_ctr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop_i && !req_take && !clear_i && !setup_data_i) |=> $stable(req_ctr));

  a_r3_take_advances: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> (req_ctr == $past(req_ctr) + 1'b1));

  a_r5_cmp_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_pop_i && !clear_i && !setup_data_i) |=> (cmp_ctr == $past(cmp_ctr) + 1'b1));

  a_r5_cmp_take_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_take |-> cmp_pop_i);

  a_r5_msg_take_advances: assert property (@(posedge clk) disable iff (!rst_n)
    msg_take |=> (msg_ctr == $past(msg_ctr) + 1'b1));

  a_r5_always_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_rsp_vld_o |-> cmp_hit) and (msg_rsp_vld_o |-> msg_hit));

  a_r6_room_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    msg_room_o |-> msg_rdy_q);

  a_r7_msg_setup_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_msg_i && !data_rdy_q && !clear_i) |=> $stable(msg_log2_o));

  a_r8_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_flush_i && !clear_i) |=> pub_upd_o[0]);

  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (req_log2_o == '0 && cmp_log2_o == '0 && msg_log2_o == '0 &&
                 req_ctr == '0 && cmp_ctr == '0 && !msg_room_o));
endmodule

bind pdr_addr_gen pdr_addr_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .setup_data_i(setup_data_i),
  .setup_msg_i(setup_msg_i), .req_pop_i(req_pop_i), .cmp_pop_i(cmp_pop_i),
  .req_flush_i(req_flush_i), .req_rsp_vld_o(req_rsp_vld_o),
  .req_rsp_hit_o(req_rsp_hit_o), .req_rsp_addr_o(req_rsp_addr_o),
  .cmp_rsp_vld_o(cmp_rsp_vld_o), .msg_rsp_vld_o(msg_rsp_vld_o),
  .cmp_hit(cmp_hit), .msg_hit(msg_hit), .req_take(req_take),
  .cmp_take(cmp_take), .msg_take(msg_take), .req_ctr(req_ctr),
  .cmp_ctr(cmp_ctr), .msg_ctr(msg_ctr), .data_rdy_q(data_rdy_q),
  .msg_rdy_q(msg_rdy_q), .msg_room_o(msg_room_o), .req_log2_o(req_log2_o),
  .cmp_log2_o(cmp_log2_o), .msg_log2_o(msg_log2_o), .pub_upd_o(pub_upd_o)
);

// File: tb/pdr_addr_gen_tb_top.sv
module pdr_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 0, setup_data_i = 0, setup_msg_i = 0;
  logic [5:0]  req_npages_i = 0, cmp_npages_i = 0;
  logic [4:0]  msg_npages_i = 0;
  logic        pt_we_i = 0;
  logic [1:0]  pt_ring_i = 0;
  logic [4:0]  pt_slot_i = 0;
  logic [35:0] pt_ppn_i = 0;
  logic        req_pop_i = 0, cmp_pop_i = 0, msg_pop_i = 0;
  logic [31:0] req_host_prod_i = 0, msg_host_prod_i = 0, msg_host_cons_i = 0;
  logic        req_flush_i = 0, cmp_flush_i = 0, msg_flush_i = 0;
  logic        req_rsp_vld_o, req_rsp_hit_o, cmp_rsp_vld_o, msg_rsp_vld_o, msg_room_o;
  logic [47:0] req_rsp_addr_o, cmp_rsp_addr_o, msg_rsp_addr_o;
  logic [5:0]  req_log2_o, cmp_log2_o, msg_log2_o;
  logic [31:0] req_cons_pub_o, cmp_prod_pub_o, msg_prod_pub_o;
  logic [2:0]  pub_upd_o;

  always #10 clk = ~clk;

  pdr_addr_gen dut_i (.*);

  int checks = 0, failures = 0;
  int m_req = 0, m_cmp = 0, m_msg = 0;
  int unsigned m_req_mask = 0, m_cmp_mask = 0, m_msg_mask = 0;
  logic [35:0] m_req_pt [32];
  logic [35:0] m_cmp_pt [32];
  logic [35:0] m_msg_pt [16];

  // Vector table: {host producer index, expected hit}
  localparam logic [32:0] REQ_VEC [8] = '{
    {32'd0, 1'b0}, {32'd3, 1'b1}, {32'd3, 1'b1}, {32'd3, 1'b1},
    {32'd3, 1'b0}, {32'd40, 1'b1}, {32'd40, 1'b1}, {32'd5, 1'b0}};

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int unsigned lg_of(input int unsigned size);
    int unsigned n = 0;
    while (((size - 1) >> n) != 0) n++;
    return n;
  endfunction

  function automatic logic [47:0] ex_addr(input logic [35:0] ppn, input int unsigned slot,
                                          input int unsigned epp, input int unsigned dsz);
    return ({12'd0, ppn} * 48'd4096) + 48'(slot % epp) * 48'(dsz);
  endfunction

  task automatic pt_write(input logic [1:0] ring, input int slot, input logic [35:0] ppn);
    pt_ring_i = ring; pt_slot_i = 5'(slot); pt_ppn_i = ppn; pt_we_i = 1;
    step();
    pt_we_i = 0;
  endtask

  task automatic req_pop(input logic [31:0] prod, input bit exp_hit, input string rq);
    int unsigned slot;
    logic [47:0] ea;
    slot = m_req & m_req_mask;
    ea = exp_hit ? ex_addr((slot / 32) < 32 ? m_req_pt[slot / 32] : 36'd0, slot, 32, 128) : 48'd0;
    req_host_prod_i = prod; req_pop_i = 1;
    step();
    req_pop_i = 0;
    chk(req_rsp_vld_o == 1'b1, "R11 req rsp_vld", 64'(req_rsp_vld_o), 1);
    chk(req_rsp_hit_o == exp_hit, {rq, " hit"}, 64'(req_rsp_hit_o), 64'(exp_hit));
    chk(req_rsp_addr_o == ea, {rq, " addr"}, 64'(req_rsp_addr_o), 64'(ea));
    if (exp_hit) m_req++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_req_pt[i] = '0; m_cmp_pt[i] = '0; end
    for (int i = 0; i < 16; i++) m_msg_pt[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R10 reset state
    chk(req_log2_o == 0 && cmp_log2_o == 0 && msg_log2_o == 0, "R10 reset log2", 64'(req_log2_o), 0);
    chk(req_cons_pub_o == 0 && cmp_prod_pub_o == 0 && msg_prod_pub_o == 0, "R10 reset pub", 64'(req_cons_pub_o), 0);
    chk(!req_rsp_vld_o && !cmp_rsp_vld_o && !msg_rsp_vld_o && !msg_room_o, "R10 reset flags", 64'(msg_room_o), 0);

    // R7: message setup before data rings is ignored
    msg_npages_i = 2; setup_msg_i = 1;
    step();
    setup_msg_i = 0;
    chk(msg_log2_o == 0, "R7 msg setup ignored log2", 64'(msg_log2_o), 0);
    chk(msg_room_o == 0, "R7 msg setup ignored room", 64'(msg_room_o), 0);

    // Page tables; R12: ring code 3 must not touch the request table
    m_req_pt[0] = 36'h100; m_req_pt[1] = 36'h103;
    m_cmp_pt[0] = 36'h200;
    m_msg_pt[0] = 36'h300; m_msg_pt[1] = 36'h301;
    pt_write(2'd0, 0, m_req_pt[0]);
    pt_write(2'd0, 1, m_req_pt[1]);
    pt_write(2'd1, 0, m_cmp_pt[0]);
    pt_write(2'd2, 0, m_msg_pt[0]);
    pt_write(2'd2, 1, m_msg_pt[1]);
    pt_write(2'd3, 0, 36'hABC);

    // R1 / R9: setup of data rings
    req_npages_i = 2; cmp_npages_i = 1; setup_data_i = 1;
    step();
    setup_data_i = 0;
    m_req_mask = (1 << lg_of(64)) - 1; m_cmp_mask = (1 << lg_of(128)) - 1;
    chk(req_log2_o == 6'(lg_of(64)), "R1 req log2", 64'(req_log2_o), 64'(lg_of(64)));
    chk(cmp_log2_o == 6'(lg_of(128)), "R1 cmp log2", 64'(cmp_log2_o), 64'(lg_of(128)));
    chk(pub_upd_o == 3'b011, "R9 setup pub_upd", 64'(pub_upd_o), 3);

    // R2 / R4 / R12 vector walk
    for (int v = 0; v < 8; v++) begin
      req_pop(REQ_VEC[v][32:1], REQ_VEC[v][0], "R2 R4 R12 vector");
    end

    // R3: wrap past ring size with free-running counter
    while (m_req < 70) req_pop(32'd70, 1'b1, "R3 wrap");
    req_pop(32'd70, 1'b0, "R2 caught up");
    req_flush_i = 1;
    step();
    req_flush_i = 0;
    chk(req_cons_pub_o == 32'd70, "R3 R8 req flush unmasked", 64'(req_cons_pub_o), 70);
    chk(pub_upd_o == 3'b001, "R8 req pub_upd", 64'(pub_upd_o), 1);
    step();
    chk(pub_upd_o == 3'b000, "R8 pub_upd one cycle", 64'(pub_upd_o), 0);
    chk(req_rsp_vld_o == 1'b0, "R11 rsp one cycle", 64'(req_rsp_vld_o), 0);
    // R8: flush with pop in the same cycle
    req_host_prod_i = 72; req_pop_i = 1; req_flush_i = 1;
    step();
    req_pop_i = 0; req_flush_i = 0; m_req++;
    chk(req_cons_pub_o == 32'd71, "R8 flush includes pop", 64'(req_cons_pub_o), 71);

    // R5: completion pops, no overflow check, wraps at 128
    for (int k = 0; k < 130; k++) begin
      int unsigned slot;
      logic [47:0] ea;
      slot = m_cmp & m_cmp_mask;
      ea = ex_addr(m_cmp_pt[slot / 128], slot, 128, 32);
      cmp_pop_i = 1;
      step();
      cmp_pop_i = 0;
      m_cmp++;
      chk(cmp_rsp_vld_o && cmp_rsp_addr_o == ea, "R5 R4 cmp addr", 64'(cmp_rsp_addr_o), 64'(ea));
    end
    cmp_flush_i = 1;
    step();
    cmp_flush_i = 0;
    chk(cmp_prod_pub_o == 32'd130, "R5 R8 cmp flush", 64'(cmp_prod_pub_o), 130);
    chk(pub_upd_o == 3'b010, "R8 cmp pub_upd", 64'(pub_upd_o), 2);

    // R7 then R1: message ring setup after data rings
    msg_npages_i = 2; setup_msg_i = 1;
    step();
    setup_msg_i = 0;
    m_msg_mask = (1 << lg_of(64)) - 1;
    chk(msg_log2_o == 6'(lg_of(64)), "R7 R1 msg log2", 64'(msg_log2_o), 64'(lg_of(64)));
    chk(pub_upd_o == 3'b100, "R9 msg setup pub_upd", 64'(pub_upd_o), 4);

    // R6: room boundaries and modular wrap
    msg_host_prod_i = 5; msg_host_cons_i = 2; #1;
    chk(msg_room_o == 1'b1, "R6 room partial", 64'(msg_room_o), 1);
    msg_host_prod_i = 66; msg_host_cons_i = 2; #1;
    chk(msg_room_o == 1'b0, "R6 room full", 64'(msg_room_o), 0);
    msg_host_prod_i = 65; msg_host_cons_i = 2; #1;
    chk(msg_room_o == 1'b1, "R6 room one left", 64'(msg_room_o), 1);
    msg_host_prod_i = 3; msg_host_cons_i = 32'hFFFF_FFFF; #1;
    chk(msg_room_o == 1'b1, "R6 room modular", 64'(msg_room_o), 1);
    msg_host_prod_i = 2; msg_host_cons_i = 3; #1;
    chk(msg_room_o == 1'b0, "R6 room negative", 64'(msg_room_o), 0);

    // R5 / R4: message pops crossing into page 1
    for (int k = 0; k < 34; k++) begin
      int unsigned slot;
      logic [47:0] ea;
      slot = m_msg & m_msg_mask;
      ea = ex_addr(m_msg_pt[slot / 32], slot, 32, 128);
      msg_pop_i = 1;
      step();
      msg_pop_i = 0;
      m_msg++;
      chk(msg_rsp_vld_o && msg_rsp_addr_o == ea, "R5 R4 msg addr", 64'(msg_rsp_addr_o), 64'(ea));
    end
    msg_flush_i = 1;
    step();
    msg_flush_i = 0;
    chk(msg_prod_pub_o == 32'd34, "R8 msg flush", 64'(msg_prod_pub_o), 34);

    // R9 / R1: re-setup with 3 request pages
    req_npages_i = 3; setup_data_i = 1;
    step();
    setup_data_i = 0;
    m_req = 0; m_req_mask = (1 << lg_of(96)) - 1;
    chk(req_log2_o == 6'(lg_of(96)), "R1 req log2 three pages", 64'(req_log2_o), 64'(lg_of(96)));
    chk(req_cons_pub_o == 0 && cmp_prod_pub_o == 0, "R9 setup zero pub", 64'(req_cons_pub_o), 0);
    req_pop(32'd1, 1'b1, "R9 slot0 after setup");

    // R10: clear zeroes tables and state
    clear_i = 1; setup_data_i = 1; req_pop_i = 1; req_host_prod_i = 9;
    step();
    clear_i = 0; setup_data_i = 0; req_pop_i = 0;
    chk(req_log2_o == 0 && cmp_log2_o == 0 && msg_log2_o == 0, "R10 clear log2", 64'(req_log2_o), 0);
    chk(req_cons_pub_o == 0 && msg_prod_pub_o == 0, "R10 clear pub", 64'(msg_prod_pub_o), 0);
    chk(req_rsp_vld_o == 0, "R10 clear beats pop", 64'(req_rsp_vld_o), 0);
    msg_host_prod_i = 0; msg_host_cons_i = 0; #1;
    chk(msg_room_o == 0, "R10 clear room", 64'(msg_room_o), 0);
    for (int i = 0; i < 32; i++) m_req_pt[i] = '0;
    m_req = 0; m_req_mask = 0;
    req_pop(32'd1, 1'b1, "R10 table cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule